// File: doc/BRIEF.md
# Fractional Multiplier with Product Register

This block is the multiply stage of a 16-bit signed fixed-point datapath. Two operand registers, X and Y, each capture a word from their own data bus when their load strobe is high. The block reads both registers as Q1.15 two's-complement fractions, which lie between -1 and just under +1. It forms their full signed product and keeps a 24-bit fractional slice of it in a product register. That register feeds the accumulate path that follows.

The product register takes a new value on every clock edge. The value is built from the operand registers as they stood before that edge, so a result appears one clock after its operands are loaded. The redundant sign bit of the 32-bit product is dropped and the low bits are discarded. The result is therefore truncated toward minus infinity with no rounding. The single operand pair that cannot be represented, -1 × -1, wraps to -1 instead of saturating. A flag output marks the cycle in which the product register holds that result.

The multiplier array comes in two variants, chosen by a parameter: an inferred multiply and an explicit radix-4 recoded partial-product array. Both give identical results.

Top module: `fmul_prod`

## Requirements
- R1: When `rst` is high at a rising clock edge, the X and Y registers, `prod_q` and `ovf_q` all become zero on that edge.
- R2: When `x_load` is high at a rising edge, X takes `x_data`. When it is low, X keeps its value. The effect is visible through `prod_q` one edge later.
- R3: When `y_load` is high at a rising edge, Y takes `y_data`. When it is low, Y keeps its value. The effect is visible through `prod_q` one edge later.
- R4: At each rising edge outside reset, `prod_q` takes bits [30:7] of the 32-bit signed integer product of X and Y as they stood before that edge. This is the product shifted left by one with its top 24 bits kept. An operand loaded at edge k therefore shows in `prod_q` after edge k+1.
- R5: The discarded low bits are dropped without rounding, so results truncate toward minus infinity. For example, 0001h × 0001h gives 000000h and FFFFh × 0001h gives FFFFFFh.
- R6: When X and Y both held 8000h before an edge, `prod_q` becomes 800000h (-1) after that edge and `ovf_q` is 1 for exactly that cycle. For every other operand pair, `ovf_q` is 0.
- R7: The inferred variant (`IMPL` = `MUL_INFER`) and the radix-4 recoded variant (`IMPL` = `MUL_BOOTH`) give the same `prod_q` and `ovf_q` for every operand pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| x_load | input | 1 | Load strobe for the X operand register |
| x_data | input | 16 | Data bus for X |
| y_load | input | 1 | Load strobe for the Y operand register |
| y_data | input | 16 | Data bus for Y |
| prod_q | output | 24 | Truncated fractional product register |
| ovf_q | output | 1 | High while `prod_q` holds the -1 × -1 wrapped result |

## Verification
Fixed corner operands are applied to both multiplier variants:
- full-scale positive and negative values, which test the sign-bit alignment;
- the smallest magnitudes, which test that truncation rounds toward minus infinity rather than toward zero;
- the 8000h pair, which tests the wrap and the flag against its near neighbours 8000h × 7FFFh and 8000h × FFFFh.

Cycles that load only X, only Y or neither tell a loaded register apart from a held one through the next product. A long run of biased random operands, compared against a 64-bit reference product, tells the two variants apart from each other and from any misplaced slice. A reset in mid-stream, followed by a load of only X, shows that both operand registers and the outputs were cleared.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

   // Selects how the multiplier array is built
   typedef enum logic [0:0] {
      MUL_INFER = 1'b0,   // plain signed multiply, left to synthesis
      MUL_BOOTH = 1'b1    // explicit radix-4 recoded partial products
   } fmul_impl_e;

   // Radix-4 recoded digit selected by a 3-bit window of the multiplier
   typedef enum logic [2:0] {
      DIG_ZERO = 3'd0,
      DIG_POS1 = 3'd1,
      DIG_POS2 = 3'd2,
      DIG_NEG1 = 3'd3,
      DIG_NEG2 = 3'd4
   } booth_dig_e;

   function automatic booth_dig_e booth_decode(input logic [2:0] win);
      booth_dig_e d;
      unique case (win)
         3'b000, 3'b111: d = DIG_ZERO;
         3'b001, 3'b010: d = DIG_POS1;
         3'b011:         d = DIG_POS2;
         3'b100:         d = DIG_NEG2;
         default:        d = DIG_NEG1;   // 101, 110
      endcase
      return d;
   endfunction

endpackage

// File: rtl/fmul_opreg.sv
module fmul_opreg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("fmul_opreg: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else if (ld) begin
         q <= d;
      end
   end

endmodule

// File: rtl/fmul_booth_array.sv
module fmul_booth_array
   import fmul_pkg::*;
#(
   parameter int W = 16,
   localparam int PW  = 2 * W,
   localparam int NPP = W / 2
) (
   input  logic [W-1:0]  mcand,
   input  logic [W-1:0]  mplier,
   output logic [PW-1:0] full
);

   if (W < 2 || (W % 2) != 0) begin : g_bad_w
      $error("fmul_booth_array: W must be even and at least 2");
   end

   logic [PW-1:0] mc_ext;
   logic [PW-1:0] mc_dbl;
   logic [W:0]    mp_ext;

   assign mc_ext = {{W{mcand[W-1]}}, mcand};
   assign mc_dbl = mc_ext << 1;
   assign mp_ext = {mplier, 1'b0};

   logic [PW-1:0] pp [NPP];

   for (genvar g = 0; g < NPP; g++) begin : g_pp
      booth_dig_e    dig;
      logic [PW-1:0] mag;

      assign dig = booth_decode(mp_ext[2*g+2 -: 3]);

      always_comb begin
         unique case (dig)
            DIG_POS1: mag = mc_ext;
            DIG_POS2: mag = mc_dbl;
            DIG_NEG1: mag = -mc_ext;
            DIG_NEG2: mag = -mc_dbl;
            default:  mag = '0;
         endcase
      end

      assign pp[g] = mag << (2 * g);
   end

   always_comb begin
      full = '0;
      for (int i = 0; i < NPP; i++) begin
         full = full + pp[i];
      end
   end

endmodule

// File: rtl/fmul_core.sv
module fmul_core
   import fmul_pkg::*;
#(
   parameter int         OP_W   = 16,
   parameter int         PROD_W = 24,
   parameter fmul_impl_e IMPL   = MUL_INFER,
   localparam int FULL_W = 2 * OP_W,
   localparam int DROP   = FULL_W - 1 - PROD_W
) (
   input  logic [OP_W-1:0]   x,
   input  logic [OP_W-1:0]   y,
   output logic [PROD_W-1:0] kept,
   output logic              illegal
);

   if (PROD_W < 1 || PROD_W > FULL_W - 1) begin : g_bad_pw
      $error("fmul_core: PROD_W must lie in 1 .. 2*OP_W-1");
   end

   logic [FULL_W-1:0] full;

   if (IMPL == MUL_BOOTH) begin : g_booth
      fmul_booth_array #(.W(OP_W)) u_array (
         .mcand  (x),
         .mplier (y),
         .full   (full)
      );
   end else begin : g_infer
      logic signed [FULL_W-1:0] sp;
      assign sp   = $signed(x) * $signed(y);
      assign full = sp;
   end

   // Drop the redundant sign bit and the low fraction bits
   assign kept = PROD_W'(full >> DROP);

   localparam logic [OP_W-1:0] MINV = {1'b1, {(OP_W-1){1'b0}}};
   assign illegal = (x == MINV) && (y == MINV);

endmodule

// File: rtl/fmul_prodreg.sv
module fmul_prodreg #(
   parameter int PROD_W = 24
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PROD_W-1:0] d,
   input  logic              ill,
   output logic [PROD_W-1:0] q,
   output logic              ovf
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q   <= '0;
         ovf <= 1'b0;
      end else begin
         q   <= d;
         ovf <= ill;
      end
   end

endmodule

// File: rtl/fmul_prod.sv
module fmul_prod
   import fmul_pkg::*;
#(
   parameter int         OP_W   = 16,
   parameter int         PROD_W = 24,
   parameter fmul_impl_e IMPL   = MUL_INFER
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              x_load,
   input  logic [OP_W-1:0]   x_data,
   input  logic              y_load,
   input  logic [OP_W-1:0]   y_data,
   output logic [PROD_W-1:0] prod_q,
   output logic              ovf_q
);

   if (OP_W < 2) begin : g_bad_op
      $error("fmul_prod: OP_W must be at least 2");
   end
   if (IMPL == MUL_BOOTH && (OP_W % 2) != 0) begin : g_bad_booth
      $error("fmul_prod: recoded array needs an even OP_W");
   end

   logic [OP_W-1:0]   x_q;
   logic [OP_W-1:0]   y_q;
   logic [PROD_W-1:0] kept;
   logic              illegal;

   fmul_opreg #(.W(OP_W)) u_xreg (
      .clk (clk), .rst (rst), .ld (x_load), .d (x_data), .q (x_q)
   );

   fmul_opreg #(.W(OP_W)) u_yreg (
      .clk (clk), .rst (rst), .ld (y_load), .d (y_data), .q (y_q)
   );

   fmul_core #(.OP_W(OP_W), .PROD_W(PROD_W), .IMPL(IMPL)) u_core (
      .x       (x_q),
      .y       (y_q),
      .kept    (kept),
      .illegal (illegal)
   );

   fmul_prodreg #(.PROD_W(PROD_W)) u_preg (
      .clk (clk),
      .rst (rst),
      .d   (kept),
      .ill (illegal),
      .q   (prod_q),
      .ovf (ovf_q)
   );

endmodule

// File: rtl/fmul_prod_chk.sv
module fmul_prod_chk #(
   parameter int OP_W   = 16,
   parameter int PROD_W = 24,
   localparam int FULL_W = 2 * OP_W
) (
   input logic              clk,
   input logic              rst,
   input logic              x_load,
   input logic [OP_W-1:0]   x_data,
   input logic              y_load,
   input logic [OP_W-1:0]   y_data,
   input logic [OP_W-1:0]   x_q,
   input logic [OP_W-1:0]   y_q,
   input logic [PROD_W-1:0] prod_q,
   input logic              ovf_q
);

   localparam logic [OP_W-1:0]   MINV = {1'b1, {(OP_W-1){1'b0}}};
   localparam logic [PROD_W-1:0] NEG1 = {1'b1, {(PROD_W-1){1'b0}}};

   function automatic logic [PROD_W-1:0] ref_kept(input logic [OP_W-1:0] a,
                                                  input logic [OP_W-1:0] b);
      logic signed [FULL_W-1:0] p;
      p = $signed(a) * $signed(b);
      return p[FULL_W-2 -: PROD_W];
   endfunction

   // R1: reset clears outputs and operands
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (prod_q == '0 && !ovf_q && x_q == '0 && y_q == '0));

   // R2: X loads or holds
   a_r2_x_load: assert property (@(posedge clk) disable iff (rst)
      x_load |=> x_q == $past(x_data));
   a_r2_x_hold: assert property (@(posedge clk) disable iff (rst)
      !x_load |=> $stable(x_q));

   // R3: Y loads or holds
   a_r3_y_load: assert property (@(posedge clk) disable iff (rst)
      y_load |=> y_q == $past(y_data));
   a_r3_y_hold: assert property (@(posedge clk) disable iff (rst)
      !y_load |=> $stable(y_q));

   // R4: product register follows operands one edge later
   a_r4_product: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> prod_q == ref_kept($past(x_q), $past(y_q)));

   // R6: flag only with the wrapped -1 result from the 8000h pair
   a_r6_flag_value: assert property (@(posedge clk) disable iff (rst)
      ovf_q |-> prod_q == NEG1);
   a_r6_flag_cause: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ovf_q == ($past(x_q) == MINV && $past(y_q) == MINV));

endmodule

bind fmul_prod fmul_prod_chk #(.OP_W(OP_W), .PROD_W(PROD_W)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .x_load (x_load),
   .x_data (x_data),
   .y_load (y_load),
   .y_data (y_data),
   .x_q    (x_q),
   .y_q    (y_q),
   .prod_q (prod_q),
   .ovf_q  (ovf_q)
);

// File: tb/test_fmul_prod.sv
`timescale 1ns/1ps
module test_fmul_prod;
   import fmul_pkg::*;

   localparam int OP_W   = 16;
   localparam int PROD_W = 24;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic x_load = 1'b0, y_load = 1'b0;
   logic [OP_W-1:0] x_data = '0, y_data = '0;
   logic [PROD_W-1:0] prod_a, prod_b;
   logic ovf_a, ovf_b;

   always #2 clk = ~clk;   // 250 MHz

   fmul_prod #(.OP_W(OP_W), .PROD_W(PROD_W), .IMPL(MUL_INFER)) i_fmul_prod (
      .clk (clk), .rst (rst),
      .x_load (x_load), .x_data (x_data),
      .y_load (y_load), .y_data (y_data),
      .prod_q (prod_a), .ovf_q (ovf_a)
   );

   fmul_prod #(.OP_W(OP_W), .PROD_W(PROD_W), .IMPL(MUL_BOOTH)) i_fmul_prod_booth (
      .clk (clk), .rst (rst),
      .x_load (x_load), .x_data (x_data),
      .y_load (y_load), .y_data (y_data),
      .prod_q (prod_b), .ovf_q (ovf_b)
   );

   typedef struct {
      logic [PROD_W-1:0] prod;
      logic              ovf;
      string             tag;
   } exp_t;

   exp_t q[$];
   exp_t stage;
   bit   stage_v = 0;
   bit   mon_on  = 0;
   int   checks  = 0;
   int   errors  = 0;
   logic [15:0] x_m = '0, y_m = '0;

   function automatic logic [23:0] model(input logic [15:0] a, input logic [15:0] b);
      longint p;
      p = longint'($signed(a)) * longint'($signed(b));
      return p[30:7];
   endfunction

   task automatic check(input string tag, input string who,
                        input logic [23:0] got_p, input logic got_o,
                        input logic [23:0] exp_p, input logic exp_o);
      checks++;
      if (got_p !== exp_p || got_o !== exp_o) begin
         errors++;
         $display("FAIL %s (%s): prod=%h ovf=%b expected prod=%h ovf=%b",
                  tag, who, got_p, got_o, exp_p, exp_o);
      end
   endtask

   // Driver: one cycle of stimulus, expected result pushed to the scoreboard
   task automatic drive(input logic xl, input logic [15:0] xd,
                        input logic yl, input logic [15:0] yd, input string tag);
      exp_t e;
      @(negedge clk);
      x_load = xl; x_data = xd;
      y_load = yl; y_data = yd;
      if (xl) x_m = xd;
      if (yl) y_m = yd;
      e.prod = model(x_m, y_m);
      e.ovf  = (x_m == 16'h8000) && (y_m == 16'h8000);
      e.tag  = tag;
      q.push_back(e);
   endtask

   task automatic op(input logic [15:0] a, input logic [15:0] b, input string tag);
      drive(1'b1, a, 1'b1, b, tag);
   endtask

   // Monitor: each item is compared two edges after it was driven
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (mon_on) begin
            if (stage_v) begin
               check(stage.tag, "infer", prod_a, ovf_a, stage.prod, stage.ovf);
               check({stage.tag, "/R7"}, "booth", prod_b, ovf_b, stage.prod, stage.ovf);
            end
            stage_v = (q.size() > 0);
            if (stage_v) stage = q.pop_front();
         end
      end
   end

   task automatic drain();
      @(negedge clk);
      x_load = 0; y_load = 0;
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   function automatic logic [15:0] pick();
      case ($urandom_range(0, 5))
         0: return 16'h8000;
         1: return 16'h7FFF;
         2: return 16'hFFFF;
         3: return 16'h0001;
         default: return 16'($urandom());
      endcase
   endfunction

   initial begin
      // R1: operands presented during reset must not load
      x_load = 1; y_load = 1; x_data = 16'h8000; y_data = 16'h8000;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset state", "infer", prod_a, ovf_a, 24'h0, 1'b0);
      check("R1 reset state", "booth", prod_b, ovf_b, 24'h0, 1'b0);
      @(negedge clk);
      x_load = 0; y_load = 0;
      rst = 0;
      mon_on = 1;

      // R4 sign and alignment corners
      op(16'h7FFF, 16'h7FFF, "R4 max*max");
      op(16'h4000, 16'h4000, "R4 half*half");
      op(16'hC000, 16'h4000, "R4 neg*pos");
      op(16'hC000, 16'hC000, "R4 neg*neg");
      op(16'h8000, 16'h7FFF, "R4 min*max");
      op(16'h8000, 16'hFFFF, "R4 min*-lsb");
      // R5 truncation toward minus infinity
      op(16'h0001, 16'h0001, "R5 lsb*lsb");
      op(16'hFFFF, 16'h0001, "R5 -lsb*lsb");
      op(16'h0003, 16'hFF81, "R5 small neg");
      // R6 wrap and flag, then neighbours clear it
      op(16'h8000, 16'h8000, "R6 min*min");
      op(16'h8000, 16'h8000, "R6 min*min again");
      op(16'h8000, 16'h8001, "R6 neighbour");
      op(16'h0000, 16'h8000, "R6 zero*min");
      // R2 / R3 load and hold
      op(16'h1234, 16'h5678, "R2 R3 both load");
      drive(1'b1, 16'hA5A5, 1'b0, 16'hFFFF, "R2 x only, y held (R3)");
      drive(1'b0, 16'h0000, 1'b1, 16'h8000, "R3 y only, x held (R2)");
      drive(1'b0, 16'h7777, 1'b0, 16'h1111, "R2 R3 both held");
      drive(1'b1, 16'h8000, 1'b0, 16'h0000, "R6 flag via x load");
      drive(1'b0, 16'h0000, 1'b0, 16'h0000, "R6 flag holds while held");

      // R4 / R7 random sweep
      for (int i = 0; i < 400; i++) begin
         drive($urandom_range(0, 3) != 0, pick(), $urandom_range(0, 3) != 0, pick(),
               "R4 random");
      end
      drain();

      // R1 mid-stream reset clears both operand registers
      op(16'h8000, 16'h8000, "R6 before reset");
      drain();
      @(negedge clk);
      rst = 1;
      @(posedge clk);
      #1;
      check("R1 mid reset", "infer", prod_a, ovf_a, 24'h0, 1'b0);
      check("R1 mid reset", "booth", prod_b, ovf_b, 24'h0, 1'b0);
      @(negedge clk);
      rst = 0;
      x_m = '0; y_m = '0;
      drive(1'b1, 16'h7FFF, 1'b0, 16'h7FFF, "R1 y cleared by reset");
      drive(1'b0, 16'h0000, 1'b1, 16'h7FFF, "R3 y loaded after reset");
      drain();

      finish_run();
   end

endmodule